// File: doc/BRIEF.md
# Transition-Count Logic Self-Test Wrapper

This block lets a small combinational circuit test itself. After a start request it drives a fixed-seed, three-bit pseudo-random pattern sequence onto the circuit's inputs for a programmed number of cycles. It watches one response bit from the circuit and counts how often that bit changes from one pattern to the next. At the end of the run the count is the signature. The block compares it with an expected value and raises a pass flag.

A test controller loads the pattern count and the expected signature, pulses start and waits for done. The expected signature comes from a known-good copy of the circuit. Pass is valid from the done pulse until the next run is accepted.

Top module: `tc_bist`

## Requirements
- R1: After reset and whenever busy is low, the pattern bus shows the seed value 3'b111, and busy, done and pass are low after reset.
- R2: While busy, the pattern bus steps once per cycle. It moves left by one bit, and the new bit 0 is old bit 2 XOR old bit 0. The order is 111, 110, 101, 010, 100, 001, 011, then back to 111. It is never all zeros.
- R3: A start seen while idle makes busy go high in the next cycle. Busy then stays high for exactly N cycles, one cycle per pattern, where N is the pattern-count input sampled with that start. A count of zero runs one pattern.
- R4: Done is high for exactly one cycle. That cycle follows the cycle of the last pattern, and busy is already low in it.
- R5: The signature is the number of patterns k from 1 to N-1 whose response bit differs from the response to pattern k-1. The response to the first pattern only sets the reference and is never counted.
- R6: Pass is 1 when the signature equals the expected-signature input sampled with the accepted start, and 0 otherwise. Pass is cleared when a run is accepted, becomes valid with done, and holds until the next accepted start.
- R7: Start asserted while busy has no effect. The run length, the expected value and the pattern sequence of the current run stay unchanged.
- R8: The signature counter does not wrap. At the largest pattern count (2^LIM_W-1) it holds every transition exactly, up to 2^LIM_W-2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request, accepted only while idle |
| pat_limit | input | LIM_W | Number of patterns for the run (0 acts as 1) |
| expect_sig | input | LIM_W | Expected transition count |
| cut_pattern | output | 3 | Pattern bus to the circuit under test |
| cut_resp | input | 1 | One-bit response from the circuit under test |
| busy | output | 1 | High while patterns are applied |
| done | output | 1 | One-cycle pulse at the end of a run |
| pass | output | 1 | Signature matched the expected value |

## Verification
The bench goes after the first sample of a run. A design that counts it as a transition reports one extra whenever the first response is 1. The bench also checks run length at count values of 0, 1, 2, 7, 8 and the maximum. Off-by-one control shows up as a wrong busy length or as a signature built from one pattern too many. Start pulses and changes to the count and expected inputs in the middle of a run catch a design that restarts or reloads its settings. A signature deliberately off by one must clear pass, which catches a comparison that always succeeds. The full 255-pattern run with a toggling truth table catches a counter that wraps.

// File: rtl/tcb_pkg.sv
package tcb_pkg;

  localparam int          PAT_W = 3;
  localparam logic [PAT_W-1:0] SEED = 3'b111;

  // one generator step: shift left, feed back bit2 ^ bit0 into bit0
  function automatic logic [PAT_W-1:0] lfsr_next(input logic [PAT_W-1:0] s);
    return {s[1:0], s[2] ^ s[0]};
  endfunction

  // final pattern index for a programmed count (zero behaves as one)
  function automatic logic [15:0] final_index(input logic [15:0] lim);
    return (lim == 16'd0) ? 16'd0 : lim - 16'd1;
  endfunction

endpackage

// File: rtl/tcb_lfsr.sv
module tcb_lfsr
  import tcb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  output logic [PAT_W-1:0] state
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state <= SEED;
    else if (load)   state <= SEED;
    else if (adv)    state <= lfsr_next(state);
  end

  // R2
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);

  // R2
  lfsr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> state != $past(state));

endmodule

// File: rtl/tcb_tcount.sv
module tcb_tcount #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sample_en,
  input  logic             first,
  input  logic             resp,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_next
);

  logic prev_bit;
  logic toggle;

  assign toggle   = sample_en && !first && (resp != prev_bit);
  assign cnt_next = cnt + {{(CNT_W-1){1'b0}}, toggle};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      prev_bit <= 1'b0;
    end else if (clear) begin
      cnt      <= '0;
      prev_bit <= 1'b0;
    end else if (sample_en) begin
      cnt      <= cnt_next;
      prev_bit <= resp;
    end
  end

  // R5
  first_not_counted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && first) |=> cnt == '0);

  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> cnt >= $past(cnt));

endmodule

// File: rtl/tcb_ctrl.sv
module tcb_ctrl
  import tcb_pkg::*;
#(
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LIM_W-1:0] pat_limit,
  input  logic [LIM_W-1:0] expect_sig,
  input  logic [LIM_W-1:0] cnt_next,
  output logic             busy,
  output logic             done,
  output logic             pass,
  output logic             start_acc,
  output logic             first_smp,
  output logic             last_smp
);

  logic [LIM_W-1:0] idx;
  logic [LIM_W-1:0] last_idx;
  logic [LIM_W-1:0] exp_q;

  assign start_acc = start && !busy;
  assign first_smp = busy && (idx == '0);
  assign last_smp  = busy && (idx == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      pass     <= 1'b0;
      idx      <= '0;
      last_idx <= '0;
      exp_q    <= '0;
    end else begin
      done <= last_smp;
      if (start_acc) begin
        busy     <= 1'b1;
        pass     <= 1'b0;
        idx      <= '0;
        last_idx <= LIM_W'(final_index(16'(pat_limit)));
        exp_q    <= expect_sig;
      end else if (busy) begin
        if (last_smp) begin
          busy <= 1'b0;
          pass <= (cnt_next == exp_q);
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R4
  end_has_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R3
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> idx <= last_idx);

  // R7
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(exp_q) && $stable(last_idx)));

  // R6
  pass_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> !pass);

endmodule

// File: rtl/tc_bist.sv
module tc_bist
  import tcb_pkg::*;
#(
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LIM_W-1:0] pat_limit,
  input  logic [LIM_W-1:0] expect_sig,
  output logic [2:0]       cut_pattern,
  input  logic             cut_resp,
  output logic             busy,
  output logic             done,
  output logic             pass
);

  localparam int CNT_W = LIM_W;

  logic             start_acc;
  logic             first_smp;
  logic             last_smp;
  logic             gen_load;
  logic [CNT_W-1:0] sig_cnt;
  logic [CNT_W-1:0] sig_next;

  assign gen_load = start_acc || last_smp;

  tcb_ctrl #(.LIM_W(LIM_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .pat_limit (pat_limit),
    .expect_sig(expect_sig),
    .cnt_next  (sig_next),
    .busy      (busy),
    .done      (done),
    .pass      (pass),
    .start_acc (start_acc),
    .first_smp (first_smp),
    .last_smp  (last_smp)
  );

  tcb_lfsr u_gen (
    .clk  (clk),
    .rst_n(rst_n),
    .load (gen_load),
    .adv  (busy),
    .state(cut_pattern)
  );

  tcb_tcount #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start_acc),
    .sample_en(busy),
    .first    (first_smp),
    .resp     (cut_resp),
    .cnt      (sig_cnt),
    .cnt_next (sig_next)
  );

  // R1
  idle_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cut_pattern == SEED);

  // R5
  idle_sig_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(sig_cnt));

endmodule

// File: tb/tc_bist_tb.sv
`timescale 1ns/1ps
module tc_bist_tb;

  localparam int LIM_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [LIM_W-1:0] pat_limit = '0;
  logic [LIM_W-1:0] expect_sig = '0;
  logic [2:0]       cut_pattern;
  logic             cut_resp;
  logic             busy, done, pass;
  logic [7:0]       tt = 8'h00;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  // combinational circuit under test: truth table indexed by the pattern
  assign cut_resp = tt[cut_pattern];

  tc_bist #(.LIM_W(LIM_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pat_limit(pat_limit),
    .expect_sig(expect_sig), .cut_pattern(cut_pattern), .cut_resp(cut_resp),
    .busy(busy), .done(done), .pass(pass)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int gen_step(input int s);
    return ((s << 1) & 6) | (((s >> 2) ^ s) & 1);
  endfunction

  function automatic int ref_sig(input int n, input logic [7:0] tab);
    int s = 7;
    int c = 0;
    bit pv = 0;
    for (int k = 0; k < n; k++) begin
      if (k > 0 && tab[s] != pv) c++;
      pv = tab[s];
      s = gen_step(s);
    end
    return c;
  endfunction

  task automatic run_one(input int lim, input logic [7:0] tab, input bit good,
                         input bit poke);
    int eff = (lim == 0) ? 1 : lim;
    int sig = ref_sig(eff, tab);
    logic [LIM_W-1:0] ev = good ? LIM_W'(sig) : LIM_W'(sig + 1);
    int s = 7;
    int cycles = 0;
    @(negedge clk);
    tt = tab; pat_limit = LIM_W'(lim); expect_sig = ev; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R7: settings changed after acceptance must not matter
    pat_limit = LIM_W'(lim + 3); expect_sig = ~ev;
    chk(busy == 1'b1, "R3", "busy after start", busy, 1);
    chk(pass == 1'b0, "R6", "pass cleared at start", pass, 0);
    while (busy && cycles < 1000) begin
      chk(cut_pattern == 3'(s) && cut_pattern != 3'b000, "R2", "pattern",
          cut_pattern, s);
      cycles++;
      s = gen_step(s);
      if (poke && cycles == 2) start = 1'b1;
      if (poke && cycles == 3) start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(cycles == eff, "R3", "busy length", cycles, eff);
    chk(done == 1'b1 && busy == 1'b0, "R4", "done at end", done, 1);
    chk(pass == good, poke ? "R7" : "R6", "pass (R5 signature)", pass, good);
    chk(cut_pattern == 3'b111, "R1", "idle seed", cut_pattern, 7);
    @(negedge clk);
    chk(done == 1'b0, "R4", "done one cycle", done, 0);
    chk(pass == good && busy == 1'b0, "R6", "pass held / no restart (R7)",
        pass, good);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && pass == 0, "R1", "reset outputs",
        {busy, done, pass}, 0);
    chk(cut_pattern == 3'b111, "R1", "reset seed", cut_pattern, 7);
    rst_n = 1'b1;
    // R5: first response 1, then constant: nothing counted
    run_one(5, 8'hFF, 1'b1, 1'b0);
    // R5: one pattern only, signature zero regardless of response
    run_one(1, 8'h80, 1'b1, 1'b0);
    run_one(0, 8'h80, 1'b1, 1'b0);
    run_one(2, 8'h80, 1'b1, 1'b0);
    run_one(7, 8'hAA, 1'b1, 1'b0);
    run_one(8, 8'h5A, 1'b0, 1'b0);
    // R8: maximum length with many toggles
    run_one(255, 8'h96, 1'b1, 1'b0);
    run_one(255, 8'h96, 1'b0, 1'b0);
    // R7: start while busy
    run_one(20, 8'h3C, 1'b1, 1'b1);
    run_one(9, 8'hC3, 1'b0, 1'b1);
    for (int i = 0; i < 20; i++) begin
      run_one(int'($urandom_range(1, 255)), 8'($urandom), 1'($urandom), 1'b0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule